// File: doc/BRIEF.md
# IO Bank Freeze and Thaw Sequencer

This block drives the control lines of one dedicated IO bank through an ordered, timed procedure that either locks the bank into a safe frozen state or brings it back to normal operation. Besides the usual pad controls (slew enable, weak pull-up, tristate, bus-hold, configuration-done), the bank carries a regulator reset, a termination reset, a termination calibration enable and a DLL reset. The sequencer only toggles these lines; the calibration engine and the DLL sit elsewhere.

A one-cycle request on `freeze_req` or `thaw_req` starts a sequence. Freezing takes three back-to-back writes. Thawing interleaves short gaps, counted in system clocks through `GAP40_CYC`, with two long waits counted in rising edges of a slow oscillator tick (`CAL_TICKS` after calibration is enabled, `SETTLE_TICKS` after bus-hold is released). The last write of either sequence comes with a one-clock `done` pulse, and `frozen` reports the state the bank was left in. After reset the bank is frozen.

Top module: `bank_freeze_ctrl`

## Requirements
- R1: After reset the outputs equal the frozen pattern: slew_n, pullup_n, tristate_n, bushold_n, cfg_done, cal_en all 0; reg_rst, oct_rst, dll_rst and frozen all 1; busy and done 0.
- R2: A freeze request drives three writes on three consecutive clocks: first slew_n, pullup_n and tristate_n go 0; then bushold_n and cfg_done go 0 while reg_rst and oct_rst go 1; then cal_en goes 0, dll_rst goes 1 and frozen goes 1.
- R3: A thaw request first clears dll_rst alone; cal_en is set alone between GAP40_CYC and GAP40_CYC+2 clocks later.
- R4: After cal_en is set, the block waits CAL_TICKS rising edges of osc_tick as seen through a two-stage synchronizer, then in one write sets bushold_n and cfg_done to 1 and clears oct_rst.
- R5: After that write, the block waits SETTLE_TICKS synchronized osc_tick rising edges, then sets pullup_n and tristate_n to 1 together.
- R6: Between GAP40_CYC and GAP40_CYC+2 clocks later reg_rst is cleared; the same spacing later slew_n goes 1 and frozen goes 0 in the same write.
- R7: done is high for exactly one clock, in the cycle the last write of a sequence becomes visible; busy is high from the clock after a request is accepted until that cycle, and low when done is high.
- R8: freeze_req and thaw_req arriving while busy is high are ignored: the running sequence completes unchanged and no second sequence follows.
- R9: When freeze_req and thaw_req are both high in an idle cycle, the freeze sequence runs.
- R10: Every write changes only the lines it names; a freeze request on an already frozen bank leaves every control output unchanged and still produces the done pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | Slow oscillator tick, asynchronous to clk |
| freeze_req | input | 1 | Start a freeze sequence when idle |
| thaw_req | input | 1 | Start a thaw sequence when idle |
| slew_n | output | 1 | Slew enable, active low |
| pullup_n | output | 1 | Weak pull-up control, active low |
| tristate_n | output | 1 | Tristate control, active low |
| bushold_n | output | 1 | Bus-hold control, active low |
| cfg_done | output | 1 | Configuration-done, active high |
| reg_rst | output | 1 | Regulator reset, active high |
| oct_rst | output | 1 | Termination reset, active high |
| cal_en | output | 1 | Termination calibration enable |
| dll_rst | output | 1 | DLL reset, active high |
| frozen | output | 1 | Bank is in the frozen state |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-clock end-of-sequence pulse |

## Verification
The ordering properties assume the requests are single-clock pulses and that osc_tick is slower than the clock, with each level held for at least two clocks so the synchronizer sees every edge. The bench drives osc_tick as a free-running square wave of four clocks per period and issues each request for exactly one clock at the falling edge, so both assumptions hold throughout. The tick-wait checks allow a window of synchronizer latency around the nominal count, because an edge seen by the synchronizer may straddle the clock on which a wait begins.

// File: rtl/bfz_pkg.sv
package bfz_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_F1, ST_F2, ST_F3,
    ST_T1, ST_W1, ST_T2, ST_W2, ST_T3, ST_W3,
    ST_T4, ST_W4, ST_T5, ST_W5, ST_T6
  } seq_st_e;

  typedef struct packed {
    logic slew_n;
    logic pullup_n;
    logic tristate_n;
    logic bushold_n;
    logic cfg_done;
    logic reg_rst;
    logic oct_rst;
    logic cal_en;
    logic dll_rst;
  } pad_ctl_t;

  localparam pad_ctl_t CTL_FROZEN = '{
    slew_n: 1'b0, pullup_n: 1'b0, tristate_n: 1'b0, bushold_n: 1'b0,
    cfg_done: 1'b0, reg_rst: 1'b1, oct_rst: 1'b1, cal_en: 1'b0,
    dll_rst: 1'b1
  };

endpackage

// File: rtl/bfz_tick_sync.sv
module bfz_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_rise
);
  // STAGES flops for metastability, one more to find the edge
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], tick_in};
  end

  assign tick_rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/bfz_wait_timer.sv
module bfz_wait_timer #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          step,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | (step & (cnt_q != '0));
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/bfz_sequencer.sv
module bfz_sequencer
  import bfz_pkg::*;
#(
  parameter int CW           = 10,
  parameter int GAP40_CYC    = 8,
  parameter int CAL_TICKS    = 1000,
  parameter int SETTLE_TICKS = 33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          freeze_req,
  input  logic          thaw_req,
  input  logic          tick_rise,
  input  logic          expired,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          tmr_step,
  output pad_ctl_t      ctl,
  output logic          frozen,
  output logic          busy,
  output logic          done
);
  localparam logic [CW-1:0] GAP_V    = CW'(GAP40_CYC);
  localparam logic [CW-1:0] CAL_V    = CW'(CAL_TICKS);
  localparam logic [CW-1:0] SETTLE_V = CW'(SETTLE_TICKS);

  seq_st_e  st_q, st_d;
  pad_ctl_t ctl_q, ctl_d;
  logic     frz_q, frz_d;
  logic     done_q, done_d;

  // next-state and write decode
  always_comb begin
    st_d     = st_q;
    ctl_d    = ctl_q;
    frz_d    = frz_q;
    done_d   = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    tmr_step = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (freeze_req)    st_d = ST_F1;
        else if (thaw_req) st_d = ST_T1;
      end
      ST_F1: begin
        ctl_d.slew_n     = 1'b0;
        ctl_d.pullup_n   = 1'b0;
        ctl_d.tristate_n = 1'b0;
        st_d = ST_F2;
      end
      ST_F2: begin
        ctl_d.bushold_n = 1'b0;
        ctl_d.cfg_done  = 1'b0;
        ctl_d.reg_rst   = 1'b1;
        ctl_d.oct_rst   = 1'b1;
        st_d = ST_F3;
      end
      ST_F3: begin
        ctl_d.cal_en  = 1'b0;
        ctl_d.dll_rst = 1'b1;
        frz_d  = 1'b1;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      ST_T1: begin
        ctl_d.dll_rst = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = GAP_V;
        st_d     = ST_W1;
      end
      ST_W1: begin
        tmr_step = 1'b1;
        if (expired) st_d = ST_T2;
      end
      ST_T2: begin
        ctl_d.cal_en = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CAL_V;
        st_d     = ST_W2;
      end
      ST_W2: begin
        tmr_step = tick_rise;
        if (expired) st_d = ST_T3;
      end
      ST_T3: begin
        ctl_d.bushold_n = 1'b1;
        ctl_d.cfg_done  = 1'b1;
        ctl_d.oct_rst   = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = SETTLE_V;
        st_d     = ST_W3;
      end
      ST_W3: begin
        tmr_step = tick_rise;
        if (expired) st_d = ST_T4;
      end
      ST_T4: begin
        ctl_d.pullup_n   = 1'b1;
        ctl_d.tristate_n = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = GAP_V;
        st_d     = ST_W4;
      end
      ST_W4: begin
        tmr_step = 1'b1;
        if (expired) st_d = ST_T5;
      end
      ST_T5: begin
        ctl_d.reg_rst = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = GAP_V;
        st_d     = ST_W5;
      end
      ST_W5: begin
        tmr_step = 1'b1;
        if (expired) st_d = ST_T6;
      end
      ST_T6: begin
        ctl_d.slew_n = 1'b1;
        frz_d  = 1'b0;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ctl_q  <= CTL_FROZEN;
      frz_q  <= 1'b1;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ctl_q  <= ctl_d;
      frz_q  <= frz_d;
      done_q <= done_d;
    end
  end

  assign ctl    = ctl_q;
  assign frozen = frz_q;
  assign done   = done_q;
  assign busy   = (st_q != ST_IDLE);
endmodule

// File: rtl/bank_freeze_ctrl.sv
module bank_freeze_ctrl
  import bfz_pkg::*;
#(
  parameter int GAP40_CYC    = 8,
  parameter int CAL_TICKS    = 1000,
  parameter int SETTLE_TICKS = 33,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_tick,
  input  logic freeze_req,
  input  logic thaw_req,
  output logic slew_n,
  output logic pullup_n,
  output logic tristate_n,
  output logic bushold_n,
  output logic cfg_done,
  output logic reg_rst,
  output logic oct_rst,
  output logic cal_en,
  output logic dll_rst,
  output logic frozen,
  output logic busy,
  output logic done
);
  localparam int MAX_A = (CAL_TICKS > SETTLE_TICKS) ? CAL_TICKS : SETTLE_TICKS;
  localparam int MAX_W = (MAX_A > GAP40_CYC) ? MAX_A : GAP40_CYC;
  localparam int CW    = $clog2(MAX_W + 1);

  logic          tick_rise;
  logic          tmr_load, tmr_step, tmr_expired;
  logic [CW-1:0] tmr_val;
  pad_ctl_t      ctl;

  bfz_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_in   (osc_tick),
    .tick_rise (tick_rise)
  );

  bfz_wait_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .step     (tmr_step),
    .expired  (tmr_expired)
  );

  bfz_sequencer #(
    .CW           (CW),
    .GAP40_CYC    (GAP40_CYC),
    .CAL_TICKS    (CAL_TICKS),
    .SETTLE_TICKS (SETTLE_TICKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .freeze_req (freeze_req),
    .thaw_req   (thaw_req),
    .tick_rise  (tick_rise),
    .expired    (tmr_expired),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .tmr_step   (tmr_step),
    .ctl        (ctl),
    .frozen     (frozen),
    .busy       (busy),
    .done       (done)
  );

  assign slew_n     = ctl.slew_n;
  assign pullup_n   = ctl.pullup_n;
  assign tristate_n = ctl.tristate_n;
  assign bushold_n  = ctl.bushold_n;
  assign cfg_done   = ctl.cfg_done;
  assign reg_rst    = ctl.reg_rst;
  assign oct_rst    = ctl.oct_rst;
  assign cal_en     = ctl.cal_en;
  assign dll_rst    = ctl.dll_rst;
endmodule

// File: rtl/bfz_checker.sv
module bfz_checker (
  input logic clk,
  input logic rst_n,
  input logic slew_n,
  input logic pullup_n,
  input logic tristate_n,
  input logic bushold_n,
  input logic cfg_done,
  input logic reg_rst,
  input logic oct_rst,
  input logic cal_en,
  input logic dll_rst,
  input logic frozen,
  input logic busy,
  input logic done
);
  // R7: completion strobe lasts one clock and only when idle again
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R1/R2: an idle frozen bank shows the full frozen pattern
  p_frozen_pattern_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !busy) |-> (!slew_n && !pullup_n && !tristate_n && !bushold_n
      && !cfg_done && reg_rst && oct_rst && !cal_en && dll_rst));

  // R6: an idle thawed bank shows the full thawed pattern
  p_thawed_pattern_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!frozen && !busy) |-> (slew_n && pullup_n && tristate_n && bushold_n
      && cfg_done && !reg_rst && !oct_rst && cal_en && !dll_rst));

  // R3: calibration is enabled only once the DLL reset is off
  p_cal_after_dll_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_en) |-> !dll_rst);

  // R4: bus-hold release happens with calibration running
  p_release_after_cal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_done) |-> (cal_en && bushold_n && !oct_rst));

  // R5: pads leave tristate only after termination reset is off
  p_pads_after_term_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tristate_n) |-> (bushold_n && !oct_rst && pullup_n));

  // R6: slew is released last, after the regulator reset
  p_slew_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slew_n) |-> (!reg_rst && tristate_n && !frozen));
endmodule

bind bank_freeze_ctrl bfz_checker u_bfz_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slew_n     (slew_n),
  .pullup_n   (pullup_n),
  .tristate_n (tristate_n),
  .bushold_n  (bushold_n),
  .cfg_done   (cfg_done),
  .reg_rst    (reg_rst),
  .oct_rst    (oct_rst),
  .cal_en     (cal_en),
  .dll_rst    (dll_rst),
  .frozen     (frozen),
  .busy       (busy),
  .done       (done)
);

// File: tb/bank_freeze_ctrl_test.sv
module bank_freeze_ctrl_test;
  localparam int G   = 8;
  localparam int CAL = 1000;
  localparam int SET = 33;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic freeze_req = 1'b0;
  logic thaw_req = 1'b0;
  logic slew_n, pullup_n, tristate_n, bushold_n, cfg_done;
  logic reg_rst, oct_rst, cal_en, dll_rst, frozen, busy, done;

  int n_chk = 0;
  int n_bad = 0;
  int tick_cnt = 0;
  int done_cnt = 0;
  bit over = 1'b0;

  always #2.5 clk = ~clk;
  initial forever #10 osc_tick = ~osc_tick;
  always @(posedge osc_tick) tick_cnt++;
  always @(negedge clk) if (done) done_cnt++;

  bank_freeze_ctrl #(.GAP40_CYC(G), .CAL_TICKS(CAL), .SETTLE_TICKS(SET)) uut (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
    .freeze_req(freeze_req), .thaw_req(thaw_req),
    .slew_n(slew_n), .pullup_n(pullup_n), .tristate_n(tristate_n),
    .bushold_n(bushold_n), .cfg_done(cfg_done), .reg_rst(reg_rst),
    .oct_rst(oct_rst), .cal_en(cal_en), .dll_rst(dll_rst),
    .frozen(frozen), .busy(busy), .done(done)
  );

  wire [9:0] obs = {slew_n, pullup_n, tristate_n, bushold_n, cfg_done,
                    reg_rst, oct_rst, cal_en, dll_rst, frozen};

  // order: slew_n pullup_n tristate_n bushold_n cfg_done reg_rst oct_rst cal_en dll_rst frozen
  localparam logic [9:0] V_FROZEN = 10'b0000011011;
  localparam logic [9:0] V_THAWED = 10'b1111100100;
  // entries 0..5 thaw steps, 6..8 freeze steps
  localparam logic [9:0] EXP_VEC [9] = '{
    10'b0000011001, 10'b0000011101, 10'b0001110101, 10'b0111110101,
    10'b0111100101, 10'b1111100100,
    10'b0001100100, 10'b0000011100, 10'b0000011011 };
  localparam int EXP_KIND [9] = '{0, 1, 2, 2, 1, 1, 0, 1, 1}; // 1 clocks, 2 ticks
  localparam int EXP_MIN  [9] = '{0, G, CAL-1, SET-1, G, G, 0, 1, 1};
  localparam int EXP_MAX  [9] = '{0, G+2, CAL+2, SET+2, G+2, G+2, 0, 1, 1};
  localparam string EXP_REQ [9] = '{"R3", "R3", "R4", "R5", "R6", "R6", "R2", "R2", "R2"};

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulse(input bit frz, input bit thw);
    @(negedge clk);
    freeze_req = frz;
    thaw_req   = thw;
    @(negedge clk);
    freeze_req = 1'b0;
    thaw_req   = 1'b0;
  endtask

  task automatic walk(input int first, input int last, input logic [9:0] start);
    logic [9:0] prev = start;
    for (int i = first; i <= last; i++) begin
      int clks = 0;
      int t0 = tick_cnt;
      bit got = 1'b0;
      while (!got && clks < 20000) begin
        @(negedge clk);
        clks++;
        if (obs != prev) got = 1'b1;
      end
      check(got && obs == EXP_VEC[i], EXP_REQ[i], "step vector", int'(obs), int'(EXP_VEC[i]));
      if (EXP_KIND[i] == 1)
        check(clks >= EXP_MIN[i] && clks <= EXP_MAX[i], EXP_REQ[i], "clock gap", clks, EXP_MIN[i]);
      else if (EXP_KIND[i] == 2)
        check((tick_cnt - t0) >= EXP_MIN[i] && (tick_cnt - t0) <= EXP_MAX[i],
              EXP_REQ[i], "tick gap", tick_cnt - t0, EXP_MIN[i] + 1);
      prev = obs;
    end
    check(done == 1'b1, "R7", "done with last write", int'(done), 1);
    check(busy == 1'b0, "R7", "idle with last write", int'(busy), 0);
    @(negedge clk);
    check(done == 1'b0, "R7", "done one clock", int'(done), 0);
  endtask

  task automatic finish_run();
    if (!over) begin
      over = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int d0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(obs == V_FROZEN, "R1", "reset pattern", int'(obs), int'(V_FROZEN));
    check(busy == 1'b0, "R1", "reset busy", int'(busy), 0);
    check(done == 1'b0, "R1", "reset done", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(obs == V_FROZEN, "R1", "after release", int'(obs), int'(V_FROZEN));

    // table walk: thaw then freeze (R3 R4 R5 R6 R2)
    pulse(1'b0, 1'b1);
    check(busy == 1'b1, "R7", "busy after accept", int'(busy), 1);
    walk(0, 5, V_FROZEN);
    pulse(1'b1, 1'b0);
    walk(6, 8, V_THAWED);

    // R10: freeze on a frozen bank changes nothing, still pulses done
    d0 = done_cnt;
    pulse(1'b1, 1'b0);
    repeat (6) @(negedge clk);
    check(obs == V_FROZEN, "R10", "refreeze pattern", int'(obs), int'(V_FROZEN));
    check(done_cnt == d0 + 1, "R10", "refreeze done count", done_cnt - d0, 1);

    // R8: requests during a thaw are ignored
    d0 = done_cnt;
    pulse(1'b0, 1'b1);
    repeat (100) @(negedge clk);
    pulse(1'b1, 1'b0);
    repeat (50) @(negedge clk);
    pulse(1'b1, 1'b1);
    begin
      int w = 0;
      while (done_cnt == d0 && w < 20000) begin @(negedge clk); w++; end
    end
    check(obs == V_THAWED, "R8", "thaw completes", int'(obs), int'(V_THAWED));
    repeat (40) @(negedge clk);
    check(obs == V_THAWED, "R8", "no second sequence", int'(obs), int'(V_THAWED));
    check(done_cnt == d0 + 1, "R8", "single done", done_cnt - d0, 1);

    // R9: both requests together in idle pick freeze
    pulse(1'b1, 1'b1);
    walk(6, 8, V_THAWED);
    check(frozen == 1'b1, "R9", "frozen after both", int'(frozen), 1);

    finish_run();
  end
endmodule